// File: doc/BRIEF.md
# Rate-1/3 Convolutional Encoder with Three Band Streams

This block takes a serial stream of information bits and encodes each one with a rate-1/3, 64-state (constraint length 7) convolutional code. Each accepted bit yields one output beat of three coded bits. Each bit of the beat comes from its own generator polynomial. The bits stay as separate lanes of a parallel word because each lane later feeds a different frequency band. When the lanes are read as one serial sequence, each step is ordered lane 0, lane 1, lane 2.

Input bits arrive on a valid/ready handshake, one bit per beat. A start-of-frame flag on a beat makes the encoder code that bit from the all-zero state. An end-of-frame flag may carry a terminate request. When it does, the encoder appends six zero-input tail beats, marked as tail, so the register ends at zero. The output is a registered beat with a valid flag. It holds its value while the consumer stalls, and input is refused for as long as the stall lasts.

Top module: `conv3_enc`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: out_code bit i is the XOR of the taps of generator i over the window {current bit, previous bit, ..., sixth previous bit}. Generator bit 6 taps the current bit, and bit 6-j taps the bit accepted j beats earlier. The generators are octal 117 on bit 0, 155 on bit 1 and 127 on bit 2.
- R3: Every accepted input bit produces exactly one output beat. The beat is valid in the cycle after acceptance, and beats keep input order.
- R4: A beat accepted with in_sof=1 is coded from the all-zero state, so input 0 gives code 000 and input 1 gives code 111, whatever came before.
- R5: Without in_sof, the register carries over from beat to beat, and idle cycles between input beats leave it unchanged.
- R6: While out_valid=1 and out_ready=0, out_code, out_tail and out_eof hold and in_ready is 0. A bit offered during the stall is accepted after it, and no bit is lost or duplicated.
- R7: A beat accepted with in_eof=1 and in_term=1 is followed by six zero-input beats with out_tail=1. in_ready stays 0 from the cycle after acceptance until the sixth tail beat has been generated. The register is then all-zero, so the next bit without in_sof codes as from zero.
- R8: out_eof=1 marks the last beat of a frame. That is the data beat when in_eof=1 and in_term=0, and the sixth tail beat when in_term=1. It is 0 on every other beat.
- R9: in_term has no effect unless in_eof=1 on the same beat: no tail beats follow, and in_ready stays available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Encoder can take an input bit |
| in_data | input | 1 | Information bit |
| in_sof | input | 1 | Beat starts a frame from the zero state |
| in_eof | input | 1 | Beat is the last data bit of the frame |
| in_term | input | 1 | With in_eof, append six zero tail beats |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_code | output | NSTR | Coded bits, bit i for band lane i |
| out_tail | output | 1 | Beat is a termination tail beat |
| out_eof | output | 1 | Last beat of the frame |

## Verification
An impulse (a single 1 after start-of-frame, then zeros) makes each lane trace its own generator's tap pattern. This separates a wrong octal value, a swapped lane or a reversed tap order. Long pseudo-random bit runs, with and without idle gaps and random consumer stalls, check register continuity and the handshake. A mid-stream start-of-frame and a bit sent right after a terminated frame show whether the state really returns to zero. Frames that end with and without the terminate request, and a terminate request without end-of-frame, check the tail count, the tail flag and where the frame-end flag falls.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
   localparam int unsigned TAP_MAX  = 16;
   localparam int unsigned DEF_K    = 7;
   localparam int unsigned DEF_NSTR = 3;
   // lane 0 in the low bits
   localparam logic [DEF_NSTR*DEF_K-1:0] DEF_GENS = {7'o127, 7'o155, 7'o117};

   typedef logic [TAP_MAX-1:0] tap_t;

   function automatic logic tap_parity(input tap_t win, input tap_t poly);
      return ^(win & poly);
   endfunction
endpackage

// File: rtl/conv3_state.sv
module conv3_state #(
   parameter int unsigned M = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         clr,
   input  logic         bit_in,
   output logic [M-1:0] st_eff
);
   // st_q[M-1] holds the newest past bit, st_q[0] the oldest
   logic [M-1:0] st_q;

   assign st_eff = clr ? '0 : st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= '0;
      else if (adv)
         st_q <= {bit_in, st_eff[M-1:1]};
   end
endmodule

// File: rtl/conv3_taps.sv
module conv3_taps
   import conv3_pkg::*;
#(
   parameter int unsigned K    = 7,
   parameter int unsigned NSTR = 3,
   parameter logic [NSTR*K-1:0] GENS = conv3_pkg::DEF_GENS
) (
   input  logic [K-1:0]    window,
   output logic [NSTR-1:0] code
);
   for (genvar g = 0; g < NSTR; g++) begin : g_lane
      localparam logic [K-1:0] POLY = GENS[g*K +: K];
      if (!POLY[K-1]) begin : g_bad_poly
         $error("generator %0d must tap the current input bit", g);
      end
      tap_t w_ext;
      tap_t p_ext;
      always_comb begin
         w_ext          = '0;
         w_ext[K-1:0]   = window;
         p_ext          = '0;
         p_ext[K-1:0]   = POLY;
      end
      assign code[g] = tap_parity(w_ext, p_ext);
   end
endmodule

// File: rtl/conv3_flush.sv
module conv3_flush #(
   parameter int unsigned LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic step,
   output logic active,
   output logic last
);
   localparam int unsigned CW = $clog2(LEN + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= CW'(LEN);
      else if (step)
         cnt_q <= cnt_q - CW'(1);
   end

   assign active = (cnt_q != '0);
   assign last   = (cnt_q == CW'(1));
endmodule

// File: rtl/conv3_enc.sv
module conv3_enc
   import conv3_pkg::*;
#(
   parameter int unsigned K    = conv3_pkg::DEF_K,
   parameter int unsigned NSTR = conv3_pkg::DEF_NSTR,
   parameter logic [NSTR*K-1:0] GENS = conv3_pkg::DEF_GENS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic            in_data,
   input  logic            in_sof,
   input  logic            in_eof,
   input  logic            in_term,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [NSTR-1:0] out_code,
   output logic            out_tail,
   output logic            out_eof
);
   localparam int unsigned M        = K - 1;
   localparam int unsigned TAIL_LEN = M;

   if (K < 3 || K > TAP_MAX) begin : g_bad_k
      $error("constraint length K=%0d out of range", K);
   end
   if (NSTR < 1) begin : g_bad_nstr
      $error("at least one output lane is required");
   end

   logic            slot_free, take, tail_go, adv, cur_bit, clr;
   logic            flush_active, flush_last, flush_start;
   logic [M-1:0]    st_eff;
   logic [K-1:0]    window;
   logic [NSTR-1:0] code_c;

   assign slot_free   = !out_valid || out_ready;
   assign in_ready    = slot_free && !flush_active;
   assign take        = in_valid && in_ready;
   assign tail_go     = flush_active && slot_free;
   assign adv         = take || tail_go;
   assign cur_bit     = flush_active ? 1'b0 : in_data;
   assign clr         = take && in_sof;
   assign flush_start = take && in_eof && in_term;

   conv3_state #(.M(M)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .clr    (clr),
      .bit_in (cur_bit),
      .st_eff (st_eff)
   );

   assign window = {cur_bit, st_eff};

   conv3_taps #(.K(K), .NSTR(NSTR), .GENS(GENS)) u_taps (
      .window (window),
      .code   (code_c)
   );

   conv3_flush #(.LEN(TAIL_LEN)) u_flush (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (flush_start),
      .step   (tail_go),
      .active (flush_active),
      .last   (flush_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
         out_tail  <= 1'b0;
         out_eof   <= 1'b0;
      end else if (adv) begin
         out_valid <= 1'b1;
         out_code  <= code_c;
         out_tail  <= tail_go;
         out_eof   <= tail_go ? flush_last : (in_eof && !in_term);
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/conv3_enc_chk.sv
module conv3_enc_chk #(
   parameter int unsigned K    = 7,
   parameter int unsigned NSTR = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            in_data,
   input logic            in_sof,
   input logic            in_eof,
   input logic            in_term,
   input logic            out_valid,
   input logic            out_ready,
   input logic [NSTR-1:0] out_code,
   input logic            out_tail,
   input logic            out_eof,
   input logic            flush_active
);
   int unsigned tail_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tail_seen <= 0;
      else if (out_valid && out_ready && out_tail)
         tail_seen <= out_eof ? 0 : tail_seen + 1;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);

   // R3
   beat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R4
   sof_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_sof && !in_data) |=> (out_code == '0));

   // R4
   sof_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_sof && in_data) |=> (out_code == '1));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_code)
                                     && $stable(out_tail) && $stable(out_eof)));

   // R6
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R7
   term_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_eof && in_term) |=> (!in_ready && flush_active));

   // R7
   tail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_tail && out_eof) |-> (tail_seen == K - 2));

   // R9
   no_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_eof) |=> !flush_active);
endmodule

bind conv3_enc conv3_enc_chk #(.K(K), .NSTR(NSTR)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_data      (in_data),
   .in_sof       (in_sof),
   .in_eof       (in_eof),
   .in_term      (in_term),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_code     (out_code),
   .out_tail     (out_tail),
   .out_eof      (out_eof),
   .flush_active (flush_active)
);

// File: tb/sim_conv3_enc.sv
`timescale 1ns/1ps
module sim_conv3_enc;
   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_data = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_term = 1'b0;
   logic out_ready = 1'b0;
   logic in_ready, out_valid, out_tail, out_eof;
   logic [2:0] out_code;

   conv3_enc u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_term(in_term),
      .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
      .out_tail(out_tail), .out_eof(out_eof)
   );

   int checks = 0, errors = 0;
   string cur_req = "R1";
   logic [4:0] exp_q[$];
   logic [5:0] hist = '0;   // hist[0] = newest past bit
   bit rdy_rand = 1'b0, rdy_force = 1'b1;

   always #10 clk = ~clk;   // 50 MHz

   always @(negedge clk) out_ready <= rdy_rand ? 1'($urandom % 2) : rdy_force;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] ref_code(logic b, logic [5:0] h);
      logic [6:0] w;
      w[6] = b;
      for (int j = 0; j < 6; j++) w[5-j] = h[j];
      ref_code[0] = ^(w & 7'o117);
      ref_code[1] = ^(w & 7'o155);
      ref_code[2] = ^(w & 7'o127);
   endfunction

   task automatic push_beat(logic b, logic tail, logic eof);
      exp_q.push_back({eof, tail, ref_code(b, hist)});
      hist = {hist[4:0], b};
   endtask

   task automatic send(logic b, logic sof, logic eof, logic term);
      bit got;
      got = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_data = b; in_sof = sof; in_eof = eof; in_term = term;
      while (!got) begin
         #2;
         got = in_ready;
         if (!got) @(negedge clk);
      end
      @(posedge clk);
      if (sof) hist = '0;
      push_beat(b, 1'b0, eof && !term);
      if (eof && term)
         for (int i = 0; i < 6; i++) push_beat(1'b0, 1'b1, i == 5);
      #1;
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_term = 1'b0;
   endtask

   always @(posedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL %s unexpected beat: actual %0h expected none", cur_req,
                     {out_eof, out_tail, out_code});
         end else begin
            chk(cur_req, "beat {eof,tail,code}", int'({out_eof, out_tail, out_code}),
                int'(exp_q.pop_front()));
         end
      end
   end

   task automatic drain(string req);
      int n = 0;
      while (exp_q.size() != 0 && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(req, "pending beats after drain", exp_q.size(), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "out_valid after reset", int'(out_valid), 0);
      chk("R1", "in_ready after reset", int'(in_ready), 1);
   endtask

   task automatic t_impulse();
      cur_req = "R2";
      rdy_rand = 1'b0; rdy_force = 1'b1;
      send(1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) send(1'b0, 1'b0, 1'b0, 1'b0);
      drain("R3");
   endtask

   task automatic t_pattern();
      cur_req = "R5";
      send(1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 60; i++) send(1'($urandom % 2), 1'b0, 1'b0, 1'b0);
      drain("R5");
   endtask

   task automatic t_gaps();
      cur_req = "R6";
      rdy_rand = 1'b1;
      for (int i = 0; i < 80; i++) begin
         send(1'($urandom % 2), 1'b0, 1'b0, 1'b0);
         repeat ($urandom % 3) @(negedge clk);
      end
      drain("R6");
      rdy_rand = 1'b0; rdy_force = 1'b1;
   endtask

   task automatic t_stall();
      cur_req = "R6";
      rdy_force = 1'b0;
      repeat (2) @(negedge clk);
      send(1'b1, 1'b0, 1'b0, 1'b0);
      fork
         send(1'b0, 1'b0, 1'b0, 1'b0);
         begin
            for (int i = 0; i < 3; i++) begin
               @(negedge clk); #3;
               chk("R6", "out_valid held", int'(out_valid), 1);
               chk("R6", "in_ready low in stall", int'(in_ready), 0);
               chk("R6", "code held", int'(out_code), int'(exp_q[0][2:0]));
            end
            rdy_force = 1'b1;
         end
      join
      drain("R6");
   endtask

   task automatic t_sof_mid();
      cur_req = "R4";
      for (int i = 0; i < 5; i++) send(1'b1, 1'b0, 1'b0, 1'b0);
      send(1'b0, 1'b1, 1'b0, 1'b0);
      send(1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) send(1'b1, 1'b0, 1'b0, 1'b0);
      send(1'b1, 1'b1, 1'b0, 1'b0);
      drain("R4");
   endtask

   task automatic t_tail();
      cur_req = "R7";
      rdy_force = 1'b1;
      send(1'b1, 1'b1, 1'b0, 1'b0);
      send(1'b1, 1'b0, 1'b0, 1'b0);
      send(1'b0, 1'b0, 1'b0, 1'b0);
      send(1'b1, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); #2;
         chk("R7", "in_ready low during tail", int'(in_ready), 0);
      end
      drain("R7");
      send(1'b1, 1'b0, 1'b0, 1'b0);   // expects 111: state back at zero
      drain("R7");
      cur_req = "R8";
      rdy_rand = 1'b1;
      for (int i = 0; i < 10; i++) send(1'($urandom % 2), 1'b0, 1'b0, 1'b0);
      send(1'b1, 1'b0, 1'b1, 1'b1);
      drain("R8");
      rdy_rand = 1'b0; rdy_force = 1'b1;
   endtask

   task automatic t_eof_plain();
      cur_req = "R8";
      send(1'b1, 1'b1, 1'b0, 1'b0);
      send(1'b0, 1'b0, 1'b1, 1'b0);
      @(negedge clk); #2;
      chk("R8", "in_ready after plain eof", int'(in_ready), 1);
      send(1'b1, 1'b0, 1'b0, 1'b0);
      drain("R8");
   endtask

   task automatic t_term_alone();
      cur_req = "R9";
      send(1'b1, 1'b1, 1'b0, 1'b0);
      send(1'b1, 1'b0, 1'b0, 1'b1);
      @(negedge clk); #2;
      chk("R9", "in_ready after term without eof", int'(in_ready), 1);
      send(1'b0, 1'b0, 1'b0, 1'b0);
      send(1'b1, 1'b0, 1'b0, 1'b0);
      drain("R9");
   endtask

   initial begin
      t_reset();
      t_impulse();
      t_pattern();
      t_gaps();
      t_stall();
      t_sof_mid();
      t_tail();
      t_eof_plain();
      t_term_alone();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule